// File: doc/BRIEF.md
# Dual-Width ALU with Flag Word

This block is the arithmetic and logic stage of a small processor datapath. It takes two 16-bit operands, an operation code and a width select, and produces a result at once, with no clock in between. Eight operations are supported: add, add with carry-in, subtract, subtract with borrow-in, AND, OR, XOR and compare. In byte mode only the low eight bits of each operand take part, and the result's upper byte reads zero.

Each operation that is strobed with `op_valid` loads six status flags into a 16-bit flag word on the next rising clock edge. These are carry, parity, auxiliary carry, zero, sign and overflow. The same word holds three control flags: trap, interrupt enable and direction. These change only through dedicated set and clear inputs. Carry also has its own set and clear inputs, for the instructions that force it. Compare updates the flags exactly as subtract does, but it raises no write-enable for the result. The flag word is the only state in the block.

Top module: `alu_flags`

## Requirements
- R1: `res` is combinational from the inputs. The codes are: 0 add, 1 add with carry-in, 2 subtract, 3 subtract with borrow-in, 4 AND, 5 OR, 6 XOR, 7 compare. Code 7 outputs the difference. `wide`=1 selects 16 bits, and `wide`=0 uses only `a[7:0]` and `b[7:0]` and drives `res[15:8]` to zero. Codes 1 and 3 use the registered carry flag as carry-in or borrow-in.
- R2: `res_we` is high exactly when `op_valid` is high and the code is not 7.
- R3: After an arithmetic or compare operation, carry (bit 0) holds the carry or borrow out of the active width's top bit, and overflow (bit 11) holds two's-complement overflow of the active width. After a logic operation (codes 4 to 6), carry, overflow and auxiliary carry are all cleared.
- R4: Auxiliary carry (bit 4) holds the carry or borrow out of bit 3 into bit 4 after an arithmetic or compare operation.
- R5: Zero (bit 6) is set when the active-width result is zero. Sign (bit 7) copies result bit 7 in byte mode and result bit 15 in word mode.
- R6: Parity (bit 2) is set when the low eight result bits hold an even number of ones, in either width.
- R7: Status flags are loaded only on a rising clock edge where `op_valid` is high. On other cycles they hold their value, except that carry still follows its commands (R8).
- R8: `cf_set` and `cf_clr` override the carry value computed by an operation in the same cycle. If both are high, set wins.
- R9: Trap (bit 8), interrupt enable (bit 9) and direction (bit 10) change only through their own set and clear inputs. Set wins over clear, and no operation affects them.
- R10: Bits 15:12 and bit 1 read 1, and bits 5 and 3 read 0. An active-low reset clears all nine flags, so the word reads 16'hF002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute strobe; loads status flags |
| op_sel | input | 3 | Operation code |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| a | input | 16 | First operand (minuend) |
| b | input | 16 | Second operand (subtrahend) |
| cf_set | input | 1 | Force carry to 1 |
| cf_clr | input | 1 | Force carry to 0 |
| tf_set | input | 1 | Set trap flag |
| tf_clr | input | 1 | Clear trap flag |
| if_set | input | 1 | Set interrupt enable |
| if_clr | input | 1 | Clear interrupt enable |
| df_set | input | 1 | Set direction flag |
| df_clr | input | 1 | Clear direction flag |
| res | output | 16 | Result |
| res_we | output | 1 | Result write-enable |
| flags | output | 16 | Flag word |

## Verification
The bench aims at the width boundary. Byte-mode operands carry nonzero upper bytes, and values such as 8'hFF+1 and 8'h7F+1 are applied. A design that leaked the upper byte, or took carry, sign or zero from the wrong bit, would report a 16-bit answer for a byte operation. Chains of add with carry and subtract with borrow check that the carry-in comes from the flag register. Compare with equal operands must set zero while `res_we` stays low, and a write-enable on compare would corrupt a destination. Carry commands are issued in the same cycle as an operation, with set and clear both high, and control-flag commands are mixed with idle cycles. A design with the wrong priority, or one that let operations disturb trap, interrupt or direction, would diverge from the bench's model.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_sel,
  input  logic        wide,
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        cf_set,
  input  logic        cf_clr,
  input  logic        tf_set,
  input  logic        tf_clr,
  input  logic        if_set,
  input  logic        if_clr,
  input  logic        df_set,
  input  logic        df_clr,
  output logic [15:0] res,
  output logic        res_we,
  output logic [15:0] flags
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7;

  logic cf, pf, af, zf, sf, tf, ief, df, of;

  logic [15:0] am, bm, r;
  logic [16:0] r17;
  logic        is_logic, is_sub, cin, msa, msb, msr;
  logic        n_cf, n_af, n_of;

  assign am  = wide ? a : {8'h00, a[7:0]};
  assign bm  = wide ? b : {8'h00, b[7:0]};
  assign cin = ((op_sel == OP_ADC) || (op_sel == OP_SBB)) && cf;
  assign is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
  assign is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBB) || (op_sel == OP_CMP);

  always_comb begin
    case (op_sel)
      OP_AND:  r17 = {1'b0, am & bm};
      OP_OR:   r17 = {1'b0, am | bm};
      OP_XOR:  r17 = {1'b0, am ^ bm};
      OP_ADD, OP_ADC: r17 = {1'b0, am} + {1'b0, bm} + {16'h0000, cin};
      default: r17 = {1'b0, am} - {1'b0, bm} - {16'h0000, cin};
    endcase
  end

  assign r   = wide ? r17[15:0] : {8'h00, r17[7:0]};
  assign msa = wide ? am[15] : am[7];
  assign msb = wide ? bm[15] : bm[7];
  assign msr = wide ? r[15]  : r[7];

  assign n_cf = !is_logic && (wide ? r17[16] : r17[8]);
  assign n_af = !is_logic && (am[4] ^ bm[4] ^ r17[4]);
  assign n_of = !is_logic && (is_sub ? ((msa != msb) && (msr != msa))
                                     : ((msa == msb) && (msr != msa)));

  assign res    = r;
  assign res_we = op_valid && (op_sel != OP_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cf, pf, af, zf, sf, of} <= '0;
      {tf, ief, df}            <= '0;
    end else begin
      if (op_valid) begin
        cf <= n_cf;
        pf <= ~^r[7:0];
        af <= n_af;
        zf <= (r == 16'h0000);
        sf <= msr;
        of <= n_of;
      end
      if (cf_set)      cf <= 1'b1;
      else if (cf_clr) cf <= 1'b0;
      if (tf_set)      tf <= 1'b1;
      else if (tf_clr) tf <= 1'b0;
      if (if_set)      ief <= 1'b1;
      else if (if_clr) ief <= 1'b0;
      if (df_set)      df <= 1'b1;
      else if (df_clr) df <= 1'b0;
    end
  end

  assign flags = {4'hF, of, df, ief, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf};
endmodule

// File: rtl/alu_flags_sva.sv
module alu_flags_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic        wide,
  input logic        cf_set,
  input logic        cf_clr,
  input logic        tf_set,
  input logic        tf_clr,
  input logic        if_set,
  input logic        if_clr,
  input logic        df_set,
  input logic        df_clr,
  input logic [15:0] res,
  input logic        res_we,
  input logic [15:0] flags
);
  a_r2_cmp_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7) |-> !res_we);

  a_r3_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel inside {3'd4, 3'd5, 3'd6}) && !cf_set && !cf_clr)
    |=> (!flags[0] && !flags[11] && !flags[4]));

  a_r5_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((flags[6] == ($past(res) == 16'h0000)) &&
                  (flags[7] == ($past(wide) ? $past(res[15]) : $past(res[7])))));

  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !cf_set && !cf_clr) |=> $stable(flags[7:0]) && $stable(flags[11]));

  a_r8_cf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cf_set |=> flags[0]);

  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tf_set && !tf_clr && !if_set && !if_clr && !df_set && !df_clr) |=> $stable(flags[10:8]));
endmodule

bind alu_flags alu_flags_sva chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .wide(wide),
  .cf_set(cf_set), .cf_clr(cf_clr), .tf_set(tf_set), .tf_clr(tf_clr),
  .if_set(if_set), .if_clr(if_clr), .df_set(df_set), .df_clr(df_clr),
  .res(res), .res_we(res_we), .flags(flags)
);

// File: tb/alu_flags_test.sv
`timescale 1ns/1ps
module alu_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic wide = 1'b0;
  logic [15:0] a = 16'h0, b = 16'h0;
  logic cf_set = 0, cf_clr = 0, tf_set = 0, tf_clr = 0;
  logic if_set = 0, if_clr = 0, df_set = 0, df_clr = 0;
  logic [15:0] res;
  logic res_we;
  logic [15:0] flags;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  int m_tf = 0, m_if = 0, m_df = 0;

  always #2.5 clk = ~clk;

  alu_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .wide(wide),
    .a(a), .b(b), .cf_set(cf_set), .cf_clr(cf_clr), .tf_set(tf_set), .tf_clr(tf_clr),
    .if_set(if_set), .if_clr(if_clr), .df_set(df_set), .df_clr(df_clr),
    .res(res), .res_we(res_we), .flags(flags)
  );

  task automatic chk(input int got, input int exp, input string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_flags();
    chk(flags[0], m_cf, "R3 R8 carry");
    chk(flags[2], m_pf, "R6 parity");
    chk(flags[4], m_af, "R4 aux carry");
    chk(flags[6], m_zf, "R5 zero");
    chk(flags[7], m_sf, "R5 sign");
    chk(flags[11], m_of, "R3 overflow");
    chk(flags[8], m_tf, "R9 trap");
    chk(flags[9], m_if, "R9 interrupt");
    chk(flags[10], m_df, "R9 direction");
    chk({flags[15:12], flags[5], flags[3], flags[1]}, 7'b1111001, "R10 fixed bits");
  endtask

  task automatic step(input bit v, input int op, input bit w, input int av, input int bv,
                      input bit cs, input bit cc, input bit ts, input bit tc,
                      input bit is, input bit ic, input bit ds, input bit dc);
    int mask, msb, x, y, c, full, r, sx, sy, sr, smin, smax, ones, n_cf, n_af, n_of;
    @(negedge clk);
    check_flags();
    op_valid = v; op_sel = op[2:0]; wide = w; a = av[15:0]; b = bv[15:0];
    cf_set = cs; cf_clr = cc; tf_set = ts; tf_clr = tc;
    if_set = is; if_clr = ic; df_set = ds; df_clr = dc;
    #1;
    mask = w ? 'hFFFF : 'hFF;
    msb  = w ? 'h8000 : 'h80;
    x = av & mask; y = bv & mask;
    c = ((op == 1) || (op == 3)) ? m_cf : 0;
    sx = (x >= msb) ? x - 2*msb : x;
    sy = (y >= msb) ? y - 2*msb : y;
    smax = msb - 1; smin = -msb;
    n_cf = 0; n_af = 0; n_of = 0;
    case (op)
      0, 1: begin
        full = x + y + c; r = full & mask; n_cf = (full > mask);
        n_af = (((x & 15) + (y & 15) + c) > 15);
        sr = sx + sy + c; n_of = (sr > smax) || (sr < smin);
      end
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      default: begin
        full = x - y - c; r = full & mask; n_cf = (full < 0);
        n_af = (((x & 15) - (y & 15) - c) < 0);
        sr = sx - sy - c; n_of = (sr > smax) || (sr < smin);
      end
    endcase
    chk(res, r, "R1 result");
    chk(res_we, (v && op != 7) ? 1 : 0, "R2 write enable");
    if (v) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      m_cf = n_cf; m_af = n_af; m_of = n_of;
      m_pf = (ones % 2 == 0); m_zf = (r == 0); m_sf = ((r & msb) != 0);
    end
    if (cs) m_cf = 1; else if (cc) m_cf = 0;
    if (ts) m_tf = 1; else if (tc) m_tf = 0;
    if (is) m_if = 1; else if (ic) m_if = 0;
    if (ds) m_df = 1; else if (dc) m_df = 0;
  endtask

  task automatic op_only(input int op, input bit w, input int av, input int bv);
    step(1, op, w, av, bv, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flags, 'hF002, "R10 reset value");
    rst_n = 1'b1;
    // byte carry out, zero, aux, parity; upper byte garbage ignored
    op_only(0, 0, 'h12FF, 'hAB01);
    op_only(0, 1, 'hFFFF, 'h0001);
    op_only(0, 0, 'h007F, 'h0001);
    op_only(0, 1, 'h7FFF, 'h0001);
    op_only(2, 0, 'h0000, 'h0001);
    op_only(3, 0, 'h0005, 'h0005);
    op_only(7, 1, 'h1234, 'h1234);
    op_only(7, 0, 'h0080, 'h0001);
    // carry chain
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    op_only(1, 1, 'h00FF, 'hFF00);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    op_only(3, 1, 'h0000, 'h0000);
    op_only(4, 1, 'hF0F0, 'h0FF0);
    op_only(5, 0, 'h0000, 'h0000);
    op_only(6, 1, 'h8001, 'h0001);
    // command priority in same cycle as op
    step(1, 0, 1, 'hFFFF, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 4, 1, 'h1, 'h1, 1, 1, 1, 1, 1, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    step(1, 2, 1, 'h8000, 'h0001, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 2, 1, 'h0001, 'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      int cmd;
      cmd = $urandom % 16;
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 2,
           ($urandom % 5 == 0) ? 'hFF80 : $urandom % 65536, $urandom % 65536,
           cmd == 1, cmd == 2, cmd == 3, cmd == 4, cmd == 5, cmd == 6,
           cmd == 7 || cmd == 9, cmd == 8 || cmd == 9);
    end
    @(negedge clk);
    check_flags();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule